// File: doc/BRIEF.md
# SDRAM Burst Column Sequencer

This block turns one read or write command into the stream of column addresses and data strobes that a synchronous DRAM burst needs. A command carries a start column, a bank select and a read/write flag. The burst settings are sampled with the command: length, wrap order and read latency. From the next cycle on, the block presents one beat per cycle. Each beat carries the column for that beat and the bank of the burst. A write beat carries a data-accept strobe in the same cycle. A read beat produces a data-valid strobe a programmed number of cycles later.

Bursts are 1, 2, 4 or 8 beats long, or full page. The wrap order is sequential or interleaved. A full-page burst steps through the whole row and wraps around until it is stopped. A terminate request cancels the beats not yet issued. Read strobes already in the latency pipeline still complete. A new legal command replaces the current burst on any cycle. Settings that are not allowed are flagged, and a command issued with them is ignored.

Top module: `sdram_burst_seq`

## Requirements
- R1: With sequential order (`cfg_ilv`=0) and a length of L beats, beat k presents the column whose upper bits match the start column and whose low log2(L) bits equal (start + k) mod L.
- R2: With interleaved order (`cfg_ilv`=1), beat k presents start column XOR k.
- R3: Length code 7 selects full page with sequential order. Beat k presents (start + k) mod 256, so column 255 is followed by column 0. Beats continue until a terminate or a new command.
- R4: `cfg_len` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 beats, and code 7 means full page. `cfg_illegal` is high in the same cycle when the code is 4 to 6, when code 7 is combined with interleave, or when `cfg_lat` is 0. A command presented with `cfg_illegal` high starts no burst.
- R5: `rd_valid` is high exactly `cfg_lat` cycles (1, 2 or 3, taken from the command) after each cycle in which a read beat is presented.
- R6: `beat` and the first column appear in the cycle after the command edge. For a write, `wr_accept` is high in every beat cycle, with no added latency.
- R7: When `cmd_stop` is sampled and no legal command is sampled at the same edge, `beat` is low from the next cycle. Read strobes of beats already issued still appear.
- R8: A legal command sampled during an active burst starts its own sequence at beat 0 in the next cycle. It takes priority over `cmd_stop` at the same edge.
- R9: `bank_out` carries the bank select of the command that started the current burst.
- R10: A burst of length L, with no terminate and no new command, presents exactly L consecutive beats.
- R11: During and right after reset, `beat`, `wr_accept` and `rd_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; rising edge only |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | Start a burst this cycle |
| cmd_write | input | 1 | 1 = write burst, 0 = read burst |
| cmd_stop | input | 1 | Terminate the active burst |
| cmd_bank | input | 1 | Bank select of the new burst |
| cmd_col | input | COL_W | Start column |
| cfg_len | input | 3 | Length code: 0..3 give 1/2/4/8 beats, 7 gives full page |
| cfg_ilv | input | 1 | 1 = interleaved order, 0 = sequential |
| cfg_lat | input | 2 | Read latency in cycles, 1 to 3 |
| beat | output | 1 | A column is being issued this cycle |
| col_out | output | COL_W | Column of the current beat |
| bank_out | output | 1 | Bank of the current burst |
| wr_accept | output | 1 | Write data is taken this cycle |
| rd_valid | output | 1 | Read data is valid this cycle |
| cfg_illegal | output | 1 | Current settings are not allowed |

## Verification
`cfg_illegal` is combinational, so the bench checks it one nanosecond after it drives the settings. `beat`, `col_out`, `bank_out` and `wr_accept` are due one rising edge after the command. They are compared at the next falling edge against a bench model that advances once per cycle. Each read beat schedules an expected `rd_valid` in a small queue, `cfg_lat` slots ahead. The queue is compared at every falling edge. This is why a terminate or a new command can be seen to cancel later beats while the strobes of beats already issued still arrive.

// File: rtl/sdram_burst_seq.sv
module sdram_burst_seq #(
  parameter int COL_W   = 8,
  parameter int MAX_LAT = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             cmd_write,
  input  logic             cmd_stop,
  input  logic             cmd_bank,
  input  logic [COL_W-1:0] cmd_col,
  input  logic [2:0]       cfg_len,
  input  logic             cfg_ilv,
  input  logic [1:0]       cfg_lat,
  output logic             beat,
  output logic [COL_W-1:0] col_out,
  output logic             bank_out,
  output logic             wr_accept,
  output logic             rd_valid,
  output logic             cfg_illegal
);
  localparam int LAT_W = 2;
  localparam logic [COL_W-1:0] ONE = {{(COL_W-1){1'b0}}, 1'b1};

  logic             act_q, wr_q, bank_q, ilv_q, full_q;
  logic [COL_W-1:0] base_q, cnt_q, mask_q;
  logic [LAT_W-1:0] lat_q;
  logic [MAX_LAT-1:0] pipe_q;

  logic             full_pg, cmd_load, rd_beat;
  logic [COL_W-1:0] len_mask;

  assign full_pg     = (cfg_len == 3'd7);
  assign len_mask    = full_pg ? '1 : ((ONE << cfg_len[1:0]) - ONE);
  assign cfg_illegal = !((!cfg_len[2] || (full_pg && !cfg_ilv)) &&
                         (cfg_lat != '0) && (cfg_lat <= LAT_W'(MAX_LAT)));
  assign cmd_load    = cmd_valid && !cfg_illegal;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      wr_q   <= 1'b0;
      bank_q <= 1'b0;
      ilv_q  <= 1'b0;
      full_q <= 1'b0;
      base_q <= '0;
      cnt_q  <= '0;
      mask_q <= '0;
      lat_q  <= LAT_W'(1);
    end else if (cmd_load) begin
      act_q  <= 1'b1;
      wr_q   <= cmd_write;
      bank_q <= cmd_bank;
      ilv_q  <= cfg_ilv;
      full_q <= full_pg;
      base_q <= cmd_col;
      cnt_q  <= '0;
      mask_q <= len_mask;
      lat_q  <= cfg_lat;
    end else if (cmd_stop) begin
      act_q  <= 1'b0;
    end else if (act_q) begin
      if (!full_q && cnt_q == mask_q) act_q <= 1'b0;
      cnt_q <= cnt_q + ONE;
    end
  end

  assign beat      = act_q;
  assign bank_out  = bank_q;
  assign wr_accept = act_q && wr_q;
  assign rd_beat   = act_q && !wr_q;
  assign col_out   = ilv_q ? (base_q ^ cnt_q)
                           : ((base_q & ~mask_q) | ((base_q + cnt_q) & mask_q));

  for (genvar i = 0; i < MAX_LAT; i++) begin : g_pipe
    if (i == MAX_LAT - 1) begin : g_top
      always_ff @(posedge clk)
        if (!rst_n) pipe_q[i] <= 1'b0;
        else        pipe_q[i] <= rd_beat && (lat_q == LAT_W'(i + 1));
    end else begin : g_mid
      always_ff @(posedge clk)
        if (!rst_n) pipe_q[i] <= 1'b0;
        else        pipe_q[i] <= pipe_q[i+1] || (rd_beat && (lat_q == LAT_W'(i + 1)));
    end
  end
  assign rd_valid = pipe_q[0];

  p_new_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_load |=> beat && col_out == $past(cmd_col) && bank_out == $past(cmd_bank));
  p_stop_ends_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_stop && !cmd_load) |=> !beat);
  p_illegal_ignored_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!beat && cmd_valid && cfg_illegal) |=> !beat);
  p_wr_zero_lat_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_load && cmd_write) |=> wr_accept);
  p_rd_lat1_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !wr_accept && lat_q == 2'd1) |=> rd_valid);
  p_rd_lat3_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !wr_accept && lat_q == 2'd3) |=> ##2 rd_valid);
  p_len_end_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !full_q && cnt_q == mask_q && !cmd_load) |=> !beat);
  p_bank_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && $past(beat) && !$past(cmd_load)) |-> $stable(bank_out));
endmodule

// File: tb/sdram_burst_seq_tb.sv
`timescale 1ns/1ps
module sdram_burst_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cmd_valid = 0, cmd_write = 0, cmd_stop = 0, cmd_bank = 0, cfg_ilv = 0;
  logic [7:0] cmd_col = '0;
  logic [2:0] cfg_len = '0;
  logic [1:0] cfg_lat = 2'd1;
  logic beat, bank_out, wr_accept, rd_valid, cfg_illegal;
  logic [7:0] col_out;

  sdram_burst_seq dut_i (.clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
    .cmd_stop(cmd_stop), .cmd_bank(cmd_bank), .cmd_col(cmd_col), .cfg_len(cfg_len),
    .cfg_ilv(cfg_ilv), .cfg_lat(cfg_lat), .beat(beat), .col_out(col_out), .bank_out(bank_out),
    .wr_accept(wr_accept), .rd_valid(rd_valid), .cfg_illegal(cfg_illegal));

  always #4 clk = ~clk;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;
  bit m_act = 0, m_wr = 0, m_bank = 0, m_ilv = 0;
  int m_start = 0, m_k = 0, m_len = 1, m_lat = 1;
  bit rdq [0:3] = '{0, 0, 0, 0};

  function automatic int len_of(int c);
    if (c <= 3) return 1 << c;
    if (c == 7) return 0;
    return -1;
  endfunction

  function automatic bit legal_f(int c, bit ilv, int lat);
    int l = len_of(c);
    return l >= 0 && !(l == 0 && ilv) && lat >= 1 && lat <= 3;
  endfunction

  function automatic int exp_col(int s, int k, int len, bit ilv);
    if (len == 0) return (s + k) % 256;
    if (ilv) return s ^ k;
    return (s & ~(len - 1) & 255) | ((s + k) & (len - 1));
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic cyc(bit v, bit w, bit s, bit b, int col, int len, bit ilv, int lat);
    bit nq [0:3];
    @(negedge clk);
    chk(m_act ? "R10" : "R7", "beat", int'(beat), int'(m_act));
    chk("R6", "wr_accept", int'(wr_accept), int'(m_act && m_wr));
    chk("R5", "rd_valid", int'(rd_valid), int'(rdq[0]));
    if (m_act) begin
      chk(m_len == 0 ? "R3" : (m_ilv ? "R2" : "R1"), "col_out", int'(col_out),
          exp_col(m_start, m_k, m_len, m_ilv));
      chk("R9", "bank_out", int'(bank_out), int'(m_bank));
    end
    cmd_valid = v; cmd_write = w; cmd_stop = s; cmd_bank = b;
    cmd_col = col[7:0]; cfg_len = len[2:0]; cfg_ilv = ilv; cfg_lat = lat[1:0];
    #1;
    chk("R4", "cfg_illegal", int'(cfg_illegal), int'(!legal_f(len, ilv, lat)));
    for (int i = 0; i < 4; i++) nq[i] = (i < 3) ? rdq[i+1] : 1'b0;
    if (m_act && !m_wr) nq[m_lat-1] = 1'b1;
    rdq = nq;
    if (v && legal_f(len, ilv, lat)) begin
      m_act = 1; m_wr = w; m_bank = b; m_start = col & 255; m_k = 0;
      m_len = len_of(len); m_ilv = ilv; m_lat = lat;
    end else if (s) m_act = 0;
    else if (m_act) begin
      if (m_len != 0 && m_k == m_len - 1) m_act = 0;
      else m_k = (m_k + 1) % 256;
    end
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 0, 0, 0, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R11", "beat in reset", int'(beat), 0);
    chk("R11", "wr_accept in reset", int'(wr_accept), 0);
    chk("R11", "rd_valid in reset", int'(rd_valid), 0);
    rst_n = 1'b1;
    idle(2);
    // R1: sequential 8 beats from 0x0D, latency 2
    cyc(1, 0, 0, 0, 8'h0D, 3, 0, 2); idle(11);
    // R2: interleaved write of 4 from 0x26
    cyc(1, 1, 0, 1, 8'h26, 2, 1, 1); idle(6);
    // R3: full page read across 255->0, then R7 terminate with pipeline draining
    cyc(1, 0, 0, 0, 8'hFC, 7, 0, 3); idle(9);
    cyc(0, 0, 1, 0, 0, 0, 0, 1); idle(6);
    // R4: illegal settings start nothing
    cyc(1, 0, 0, 0, 8'h10, 7, 1, 1); idle(3);
    cyc(1, 1, 0, 0, 8'h10, 5, 0, 1); idle(3);
    cyc(1, 0, 0, 0, 8'h10, 1, 0, 0); idle(3);
    // R8: interrupt read with write; command wins over stop
    cyc(1, 0, 0, 0, 8'h40, 3, 0, 3); idle(2);
    cyc(1, 1, 1, 1, 8'h83, 1, 0, 1); idle(6);
    // R10: single-beat bursts
    cyc(1, 0, 0, 1, 8'h77, 0, 1, 1); cyc(1, 1, 0, 0, 8'h78, 0, 0, 2); idle(5);
    for (int n = 0; n < 4000; n++) begin
      int r = $urandom_range(0, 15);
      int lc = $urandom_range(0, 9);
      int len = (lc < 4) ? lc : ((lc < 8) ? 7 : 5);
      int lat = ($urandom_range(0, 15) == 0) ? 0 : $urandom_range(1, 3);
      cyc(r < 2, $urandom_range(0, 1) == 1, r == 2, $urandom_range(0, 1) == 1,
          $urandom_range(0, 255), len, $urandom_range(0, 3) == 0, lat);
    end
    idle(6);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end
endmodule